// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper with Blanking

This block regulates motor winding current by deciding, cycle by cycle, whether the bridge should drive or recirculate. It receives a comparator flag that goes high when the sensed current voltage is above the reference. When that flag is seen while the controller is sensing, the drive is switched off for a fixed, programmable number of clock cycles. The off-time does not depend on the current level. The on-time is simply however long the current takes to climb back to the threshold.

Every return from off to on opens a blanking window. During this window the comparator is ignored, so ringing from the switching edge cannot cause a false trip. One shared down-counter times the off interval and then the blanking interval that always follows it. Both lengths are cycle counts taken from input ports. The ports are sampled only while the block is disabled. A one-cycle strobe marks every start of an off interval, so the phase sequencer or a monitor can count chop cycles.

Top module: `chop_regulator`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `driveOn` is 1 and `chopStrobe` is 0. Reset also clears the sampled off and blank counts to 0.
- R2: The comparator flag passes through two synchronizer flops and then the state register. A flag that goes high while the controller is sensing turns `driveOn` low after the third rising clock edge, and not earlier.
- R3: An off interval keeps `driveOn` at 0 for exactly max(off count, 1) cycles, whatever the comparator does.
- R4: Each off interval is followed by a blanking window of exactly the blank count in cycles, during which `driveOn` is 1 even when the flag is high. A blank count of 0 skips the window, and sensing begins in the first on cycle.
- R5: If the synchronized flag is still high when sensing begins, the drive stays on for one sensing cycle and then goes off again. With the flag held high, the pattern therefore repeats every max(off,1) + blank + 1 cycles.
- R6: While the synchronized flag is low during sensing, `driveOn` stays 1 indefinitely.
- R7: `chopStrobe` is 1 for exactly one cycle: the first cycle of each off interval. It is 0 at all other times.
- R8: With `enable` low at a rising edge, the next cycle has `driveOn` = 1 and `chopStrobe` = 0, and the timer is cleared. After `enable` returns high, one blanking cycle passes before sensing resumes.
- R9: `offCount` and `blankCount` are captured on every edge at which `enable` is low. Changing them while enabled has no effect on the running pattern.
- R10: A one-cycle comparator pulse that falls entirely inside a blanking window causes no off interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | High to run; low holds the controller in blanking with the timer cleared and samples the counts |
| tripRaw | input | 1 | Comparator flag, high when the sensed current is above the reference; asynchronous |
| offCount | input | OFF_W | Off-time length in clock cycles (0 is treated as 1) |
| blankCount | input | BLANK_W | Blanking length in clock cycles (0 means no blanking) |
| driveOn | output | 1 | 1 = bridge drives, 0 = recirculate |
| chopStrobe | output | 1 | One-cycle pulse in the first cycle of each off interval |

## Verification
A flag change at `tripRaw` shows up at `driveOn` three rising edges later. A disable shows up one edge later. A reset shows up at once. The bench drives inputs just after a rising edge and samples just after the following edges, so each check looks at the cycle index the requirement predicts. For a flag held high, the expected level and strobe of every cycle follow from the formula (i-1) mod (max(off,1)+blank+1). This is swept over every off count from 0 to 4 and every blank count from 0 to 5. Directed runs cover the synchronizer delay, pulses that fall inside blanking, mid-off disable and mid-off reset.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    ST_BLANK = 2'd0,
    ST_SENSE = 2'd1,
    ST_OFF   = 2'd2
  } chopState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic idle;       // disabled: clear timer, capture counts
    logic loadOff;    // start off interval
    logic loadBlank;  // start blanking interval
    logic dec;        // count down
  } timerCmd_t;

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[g] <= 1'b0;
          else       stage[g] <= din;
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[g] <= 1'b0;
          else       stage[g] <= stage[g-1];
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/chop_datapath.sv
module chop_datapath
  import chop_pkg::*;
#(
  parameter int OFF_W   = 8,
  parameter int BLANK_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  timerCmd_t          cmd,
  input  logic [OFF_W-1:0]   offCount,
  input  logic [BLANK_W-1:0] blankCount,
  output logic               timerZero,
  output logic               blankZero,
  output logic [OFF_W-1:0]   offCfg
);
  localparam int CNT_W = (OFF_W > BLANK_W) ? OFF_W : BLANK_W;

  logic [OFF_W-1:0]   offReg;
  logic [BLANK_W-1:0] blankReg;
  logic [CNT_W-1:0]   timer;
  logic [OFF_W-1:0]   offLenM1;
  logic [BLANK_W-1:0] blankLenM1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offReg   <= '0;
      blankReg <= '0;
    end else if (cmd.idle) begin
      offReg   <= offCount;
      blankReg <= blankCount;
    end
  end

  assign offLenM1   = (offReg == '0) ? '0 : offReg - 1'b1;
  assign blankLenM1 = (blankReg == '0) ? '0 : blankReg - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timer <= '0;
    else if (cmd.idle)      timer <= '0;
    else if (cmd.loadOff)   timer <= CNT_W'(offLenM1);
    else if (cmd.loadBlank) timer <= CNT_W'(blankLenM1);
    else if (cmd.dec)       timer <= timer - 1'b1;
  end

  assign timerZero = (timer == '0);
  assign blankZero = (blankReg == '0);
  assign offCfg    = offReg;
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       tripSync,
  input  logic       timerZero,
  input  logic       blankZero,
  output timerCmd_t  cmd,
  output chopState_t state,
  output logic       driveOn,
  output logic       chopStrobe
);
  chopState_t nextState;
  logic       nextStrobe;

  always_comb begin
    nextState  = state;
    cmd        = '0;
    nextStrobe = 1'b0;
    if (!enable) begin
      nextState = ST_BLANK;
      cmd.idle  = 1'b1;
    end else begin
      case (state)
        ST_BLANK: begin
          if (timerZero) nextState = ST_SENSE;
          else           cmd.dec   = 1'b1;
        end
        ST_SENSE: begin
          if (tripSync) begin
            nextState   = ST_OFF;
            cmd.loadOff = 1'b1;
            nextStrobe  = 1'b1;
          end
        end
        ST_OFF: begin
          if (timerZero) begin
            if (blankZero) nextState = ST_SENSE;
            else begin
              nextState     = ST_BLANK;
              cmd.loadBlank = 1'b1;
            end
          end else begin
            cmd.dec = 1'b1;
          end
        end
        default: nextState = ST_BLANK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_BLANK;
      chopStrobe <= 1'b0;
    end else begin
      state      <= nextState;
      chopStrobe <= nextStrobe;
    end
  end

  assign driveOn = (state != ST_OFF);
endmodule

// File: rtl/chop_regulator.sv
module chop_regulator
  import chop_pkg::*;
#(
  parameter int OFF_W       = 8,
  parameter int BLANK_W     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               tripRaw,
  input  logic [OFF_W-1:0]   offCount,
  input  logic [BLANK_W-1:0] blankCount,
  output logic               driveOn,
  output logic               chopStrobe
);
  logic             tripSync;
  logic             timerZero;
  logic             blankZero;
  logic [OFF_W-1:0] offCfg;
  timerCmd_t        cmd;
  chopState_t       ctrlState;

  chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(tripRaw), .dout(tripSync)
  );

  chop_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .tripSync(tripSync),
    .timerZero(timerZero), .blankZero(blankZero), .cmd(cmd),
    .state(ctrlState), .driveOn(driveOn), .chopStrobe(chopStrobe)
  );

  chop_datapath #(.OFF_W(OFF_W), .BLANK_W(BLANK_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .offCount(offCount),
    .blankCount(blankCount), .timerZero(timerZero),
    .blankZero(blankZero), .offCfg(offCfg)
  );
endmodule

// File: rtl/chop_regulator_chk.sv
module chop_regulator_chk
  import chop_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             driveOn,
  input logic             chopStrobe,
  input chopState_t       state,
  input logic             tripSync,
  input logic [OFF_W-1:0] offCfg
);
  logic [OFF_W:0] offRun;
  logic [OFF_W:0] offExp;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)        offRun <= '0;
    else if (driveOn) offRun <= '0;
    else              offRun <= offRun + 1'b1;

  assign offExp = (offCfg == '0) ? (OFF_W+1)'(1) : (OFF_W+1)'(offCfg);

  // R3
  off_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(driveOn) && $past(enable)) |-> (offRun == offExp));

  // R4
  blank_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && state == ST_BLANK) |=> driveOn);

  // R6
  no_trip_stays_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && state == ST_SENSE && !tripSync) |=> driveOn);

  // R7
  strobe_at_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    chopStrobe |-> (!driveOn && $past(driveOn)));

  // R7
  fall_has_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveOn) |-> chopStrobe);

  // R8
  disable_forces_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (driveOn && !chopStrobe));
endmodule

bind chop_regulator chop_regulator_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .driveOn(driveOn),
  .chopStrobe(chopStrobe), .state(ctrlState), .tripSync(tripSync),
  .offCfg(offCfg)
);

// File: tb/tb_chop_regulator.sv
`timescale 1ns/1ps
module tb_chop_regulator;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       tripRaw = 1'b0;
  logic [7:0] offCount = '0;
  logic [5:0] blankCount = '0;
  logic       driveOn;
  logic       chopStrobe;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  chop_regulator dut (
    .clk(clk), .rstN(rstN), .enable(enable), .tripRaw(tripRaw),
    .offCount(offCount), .blankCount(blankCount),
    .driveOn(driveOn), .chopStrobe(chopStrobe)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Flag held high; expected level from (i-1) mod period
  task automatic runPattern(input int offP, input int blankP, input int n,
                            input int chgAt, input int newOff, input int newBlank,
                            input string tag);
    int offLen, period, mism, strobes, expStrobes, j;
    bit expOn, expS;
    enable = 1'b0; tripRaw = 1'b1;
    offCount = 8'(offP); blankCount = 6'(blankP);
    repeat (3) tick();
    enable = 1'b1;
    offLen = (offP == 0) ? 1 : offP;
    period = offLen + blankP + 1;
    mism = 0; strobes = 0; expStrobes = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (i == chgAt) begin
        offCount = 8'(newOff); blankCount = 6'(newBlank);
      end
      j = (i == 0) ? -1 : (i - 1) % period;
      expOn = (i == 0) || (j >= offLen);
      expS  = (i > 0) && (j == 0);
      if (driveOn != expOn) mism++;
      if (chopStrobe != expS) mism++;
      if (chopStrobe) strobes++;
      if (expS) expStrobes++;
    end
    chk({tag, " cycle pattern mismatches"}, mism, 0);
    chk("R7 strobe count", strobes, expStrobes);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int onCnt;
    // R1 reset state
    repeat (3) tick();
    chk("R1 driveOn in reset", driveOn, 1);
    chk("R1 chopStrobe in reset", chopStrobe, 0);
    rstN = 1'b1;
    tick();
    chk("R1 driveOn after reset", driveOn, 1);
    chk("R1 chopStrobe after reset", chopStrobe, 0);

    // R3 R4 R5 sweep, flag held high
    for (int o = 0; o <= 4; o++)
      for (int b = 0; b <= 5; b++)
        runPattern(o, b, 3 * ((o == 0 ? 1 : o) + b + 1) + 2, -1, 0, 0, "R3/R4/R5");

    // R9: port change while enabled ignored
    runPattern(3, 2, 30, 2, 7, 0, "R9");

    // R2 synchronizer latency, R6 stays on, R4 blanking
    enable = 1'b0; tripRaw = 1'b0; offCount = 8'd2; blankCount = 6'd3;
    repeat (3) tick();
    enable = 1'b1;
    repeat (5) tick();
    tripRaw = 1'b1;
    tick(); chk("R2 on after 1 edge", driveOn, 1);
    tick(); chk("R2 on after 2 edges", driveOn, 1);
    tripRaw = 1'b0;
    tick(); chk("R2 off after 3 edges", driveOn, 0);
    tick(); chk("R3 still off", driveOn, 0);
    onCnt = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (driveOn) onCnt++;
    end
    chk("R6 on while flag low", onCnt, 20);

    // R10 pulse inside blanking ignored
    enable = 1'b0; offCount = 8'd2; blankCount = 6'd8;
    repeat (3) tick();
    enable = 1'b1;
    repeat (5) tick();
    tripRaw = 1'b1;
    tick(); tick();
    tripRaw = 1'b0;
    tick(); chk("R10 chop begins", driveOn, 0);
    chk("R7 strobe at chop", chopStrobe, 1);
    tick();
    tick(); chk("R4 blank starts", driveOn, 1);
    tick();
    tripRaw = 1'b1;
    tick();
    tripRaw = 1'b0;
    onCnt = 0;
    for (int i = 0; i < 24; i++) begin
      tick();
      if (driveOn) onCnt++;
    end
    chk("R10 pulse in blank ignored", onCnt, 24);

    // R8 disable during off, then restart
    enable = 1'b0; tripRaw = 1'b1; offCount = 8'd5; blankCount = 6'd2;
    repeat (3) tick();
    enable = 1'b1;
    tick(); chk("R8 first cycle on", driveOn, 1);
    tick(); chk("R3 off entered", driveOn, 0);
    enable = 1'b0;
    tick(); chk("R8 disable forces on", driveOn, 1);
    chk("R8 strobe low when disabled", chopStrobe, 0);
    enable = 1'b1;
    tick(); chk("R8 one blank cycle after enable", driveOn, 1);
    tick(); chk("R8 sensing resumes", driveOn, 0);

    // R1 asynchronous reset during off
    tick();
    rstN = 1'b0;
    #1;
    chk("R1 async reset forces on", driveOn, 1);
    tick();
    rstN = 1'b1; tripRaw = 1'b0;
    tick();
    chk("R1 strobe low after reset", chopStrobe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule